// File: doc/BRIEF.md
# Random Word Generator Register Front End

This block is the bus-facing side of a hardware random bit generator. A host talks to it through single-cycle 32-bit word reads and writes on a plain select/write/address/data bus. The host turns word production on through a control register and can hold two sections in reset, the generator core and the bit source, each through its own register. It reads finished random words one at a time from a data register that pops an internal FIFO, and a count register tells it how many words are waiting.

A sticky interrupt status register collects two health faults and two progress events. Each bit is cleared by writing a one to it. Either health fault stops production until the host clears it, and an interrupt output stays high while any status bit is set. The real entropy source is replaced by a seeded xorshift stand-in, and the two health faults come in on pins.

Read data is combinational and valid in the cycle of the access. The pop that a data read causes, and every register write, take effect at the clock edge that ends that cycle.

Top module: `rng_regfront`

## Requirements
- R1: After reset, control, both soft-reset registers, status and FIFO count all read zero and irq_o is low.
- R2: Control (offset 0x00) is a 32-bit read/write register. Production is allowed only when bits 12:0 equal exactly 1. A value of 3 or 0 stops it, and every bit reads back as written.
- R3: Produced words follow x = x^(x<<13); x ^= x>>17; x ^= x<<5, starting from 32'h2545F491. The first word after reset or after a restart is that seed, and each pushed word advances the sequence once.
- R4: The FIFO holds 16 words. Reading offset 0x20 returns the oldest word and removes it. Offset 0x24 gives the word count in bits 7:0 with the upper bits zero. At most one word enters per cycle, and only when the FIFO is not full.
- R5: A read of 0x20 while the FIFO is empty returns zero and leaves the count at zero.
- R6: Bit 0 of offset 0x04 (core hold) and bit 0 of offset 0x08 (source hold) read back as written, with the other bits zero. While either is 1 the FIFO is emptied, production is blocked and the generator is returned to its seed.
- R7: While the core hold is 1 the startup flag is cleared and its cycle timer restarts. The source hold does neither.
- R8: Status (offset 0x18) has bit 31 lockout, bit 17 startup done, bit 5 statistical failure and bit 0 word total, and the other bits read zero. Writing 1 to a bit clears it, and writing 0 leaves it. A set event in the same cycle as a clear wins.
- R9: The lockout and failure pins set their flags one cycle later. The flags stay set after the pin falls. While either flag is set no word enters the FIFO, but buffered words can still be read. After a clear, production resumes where the sequence stopped.
- R10: The startup flag sets on the 64th clock edge at which production is allowed (enable is 1 and both holds are 0) since reset or the last core hold. It sets only once per such period.
- R11: The word-total flag sets each time 256 words have entered the FIFO since reset or the last hold.
- R12: irq_o is high exactly while at least one status flag is set.
- R13: Reads of any other offset return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| fault_lock_i | input | 1 | Health lockout event from the source |
| fault_stat_i | input | 1 | Statistical test failure event from the source |
| irq_o | output | 1 | High while any status flag is set |

## Verification
The assertions assume that bus_sel, bus_wr and the fault pins are known and settled at every rising edge after reset. They also assume that each access lasts one cycle, so a data read held for several cycles pops several words. The bench changes every input on the falling edge and holds each access for exactly one cycle. It raises a fault pin only as a one-cycle pulse, so the stickiness of each flag is seen after the pin has already dropped. It sequences the holds as a set followed later by a clear, and it waits for the FIFO to fill before it starts draining, so every expected word and count is known in advance.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int DATA_W      = 32;
    localparam int EN_W        = 13;
    localparam int CNT_FIELD_W = 8;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CORE  = 8'h04;
    localparam logic [7:0] OFF_SRC   = 8'h08;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_DATA  = 8'h20;
    localparam logic [7:0] OFF_COUNT = 8'h24;

    localparam logic [EN_W-1:0] EN_ON = EN_W'(1);

    localparam int BIT_LOCK  = 31;
    localparam int BIT_START = 17;
    localparam int BIT_FAIL  = 5;
    localparam int BIT_TOTAL = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CORE,
        SEL_SRC,
        SEL_STAT,
        SEL_DATA,
        SEL_COUNT
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    typedef struct packed {
        logic lockout;
        logic startup;
        logic statfail;
        logic total;
    } hflags_t;

    function automatic logic [DATA_W-1:0] xs_next(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input hflags_t f);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_LOCK]  = f.lockout;
        w[BIT_START] = f.startup;
        w[BIT_FAIL]  = f.statfail;
        w[BIT_TOTAL] = f.total;
        return w;
    endfunction

    function automatic hflags_t stat_pick(input logic [DATA_W-1:0] w);
        hflags_t f;
        f.lockout  = w[BIT_LOCK];
        f.startup  = w[BIT_START];
        f.statfail = w[BIT_FAIL];
        f.total    = w[BIT_TOTAL];
        return f;
    endfunction

endpackage

// File: rtl/rng_decode.sv
module rng_decode
    import rng_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output access_t           acc
);

    reg_sel_e sel;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_CTRL))  sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFF_CORE))  sel = SEL_CORE;
        else if (bus_addr == ADDR_W'(OFF_SRC))   sel = SEL_SRC;
        else if (bus_addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
        else if (bus_addr == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
        else if (bus_addr == ADDR_W'(OFF_COUNT)) sel = SEL_COUNT;
        else                                     sel = SEL_NONE;
    end

    always_comb begin
        acc.rd  = bus_sel && !bus_wr;
        acc.wr  = bus_sel && bus_wr;
        acc.sel = bus_sel ? sel : SEL_NONE;
    end

endmodule

// File: rtl/rng_src.sv
module rng_src
    import rng_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 32'h2545_F491
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst || restart) word <= SEED;
        else if (advance)   word <= xs_next(word);
    end

endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rng_health.sv
module rng_health
    import rng_pkg::*;
#(
    parameter int STARTUP_CYC = 64,
    parameter int TOTAL_WORDS = 256,
    localparam int SU_W = $clog2(STARTUP_CYC),
    localparam int TW_W = $clog2(TOTAL_WORDS)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    core_hold,
    input  logic    flush,
    input  logic    gen_allowed,
    input  logic    pushed,
    input  logic    fault_lock,
    input  logic    fault_stat,
    input  hflags_t clr,
    output hflags_t flags
);

    logic [SU_W-1:0] su_cnt;
    logic            su_done;
    logic            su_hit;
    logic [TW_W-1:0] tw_cnt;
    logic            tw_hit;

    assign su_hit = gen_allowed && !su_done && (su_cnt == SU_W'(STARTUP_CYC - 1));
    assign tw_hit = pushed && (tw_cnt == TW_W'(TOTAL_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || core_hold) begin
            su_cnt  <= '0;
            su_done <= 1'b0;
        end else if (gen_allowed && !su_done) begin
            if (su_hit) su_done <= 1'b1;
            else        su_cnt  <= su_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)  tw_cnt <= '0;
        else if (tw_hit)   tw_cnt <= '0;
        else if (pushed)   tw_cnt <= tw_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.lockout  <= fault_lock | (flags.lockout & ~clr.lockout);
            flags.statfail <= fault_stat | (flags.statfail & ~clr.statfail);
            flags.total    <= tw_hit | (flags.total & ~clr.total);
            flags.startup  <= core_hold ? 1'b0
                                        : (su_hit | (flags.startup & ~clr.startup));
        end
    end

endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
    import rng_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                FIFO_DEPTH  = 16,
    parameter int                STARTUP_CYC = 64,
    parameter int                TOTAL_WORDS = 256,
    parameter logic [DATA_W-1:0] SEED        = 32'h2545_F491
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fault_lock_i,
    input  logic              fault_stat_i,
    output logic              irq_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    access_t           acc;
    logic [DATA_W-1:0] ctrl_q;
    logic              core_hold_q;
    logic              src_hold_q;
    logic              hold_any;
    logic              gen_allowed;
    logic              health_block;
    logic              push_req;
    logic              data_rd;
    logic              lock_clr;
    hflags_t           flags;
    hflags_t           clr;
    logic [DATA_W-1:0] gen_word;
    logic [DATA_W-1:0] fifo_dout;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full;
    logic              fifo_empty;

    rng_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            core_hold_q <= 1'b0;
            src_hold_q  <= 1'b0;
        end else if (acc.wr) begin
            case (acc.sel)
                SEL_CTRL: ctrl_q      <= bus_wdata;
                SEL_CORE: core_hold_q <= bus_wdata[0];
                SEL_SRC:  src_hold_q  <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    assign hold_any     = core_hold_q | src_hold_q;
    assign gen_allowed  = (ctrl_q[EN_W-1:0] == EN_ON) && !hold_any;
    assign health_block = flags.lockout | flags.statfail;
    assign push_req     = gen_allowed && !health_block && !fifo_full;
    assign data_rd      = acc.rd && (acc.sel == SEL_DATA);
    assign clr          = (acc.wr && acc.sel == SEL_STAT) ? stat_pick(bus_wdata) : '0;
    assign lock_clr     = clr.lockout;

    rng_src #(.SEED(SEED)) u_src (
        .clk     (clk),
        .rst     (rst),
        .restart (hold_any),
        .advance (push_req),
        .word    (gen_word)
    );

    rng_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (hold_any),
        .push  (push_req),
        .din   (gen_word),
        .pop   (data_rd),
        .dout  (fifo_dout),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    rng_health #(.STARTUP_CYC(STARTUP_CYC), .TOTAL_WORDS(TOTAL_WORDS)) u_health (
        .clk         (clk),
        .rst         (rst),
        .core_hold   (core_hold_q),
        .flush       (hold_any),
        .gen_allowed (gen_allowed),
        .pushed      (push_req),
        .fault_lock  (fault_lock_i),
        .fault_stat  (fault_stat_i),
        .clr         (clr),
        .flags       (flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            case (acc.sel)
                SEL_CTRL:  bus_rdata = ctrl_q;
                SEL_CORE:  bus_rdata = {31'b0, core_hold_q};
                SEL_SRC:   bus_rdata = {31'b0, src_hold_q};
                SEL_STAT:  bus_rdata = stat_word(flags);
                SEL_DATA:  bus_rdata = fifo_empty ? '0 : fifo_dout;
                SEL_COUNT: bus_rdata = {{(DATA_W-CNT_FIELD_W){1'b0}}, CNT_FIELD_W'(fifo_cnt)};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = |flags;

endmodule

// File: rtl/rng_regfront_chk.sv
module rng_regfront_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_any,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             health_block,
    input logic             data_rd,
    input logic [31:0]      bus_rdata,
    input logic             fault_stat_i,
    input logic             irq_o,
    input logic             lock_flag,
    input logic             lock_clr
);

    // R4: never more words than the FIFO depth
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH));

    // R6: a hold empties the FIFO by the next cycle
    a_r6_hold_flush: assert property (@(posedge clk) disable iff (rst)
        hold_any |=> (fifo_cnt == '0));

    // R9: with a health flag up and no pop, the count does not move
    a_r9_no_fill: assert property (@(posedge clk) disable iff (rst)
        (health_block && !data_rd && !hold_any) |=> $stable(fifo_cnt));

    // R9: lockout stays until cleared by a one
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (lock_flag && !lock_clr) |=> lock_flag);

    // R12: a failure pulse raises the interrupt next cycle
    a_r12_irq_on_fail: assert property (@(posedge clk) disable iff (rst)
        fault_stat_i |=> irq_o);

    // R5: an empty data read returns zero
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (data_rd && fifo_cnt == '0) |-> (bus_rdata == '0));

endmodule

bind rng_regfront rng_regfront_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hold_any     (hold_any),
    .fifo_cnt     (fifo_cnt),
    .health_block (health_block),
    .data_rd      (data_rd),
    .bus_rdata    (bus_rdata),
    .fault_stat_i (fault_stat_i),
    .irq_o        (irq_o),
    .lock_flag    (flags.lockout),
    .lock_clr     (lock_clr)
);

// File: tb/test_rng_regfront.sv
module test_rng_regfront;

    localparam logic [31:0] SEED = 32'h2545_F491;
    localparam logic [7:0] A_CTRL = 8'h00, A_CORE = 8'h04, A_SRC = 8'h08,
                           A_STAT = 8'h18, A_DATA = 8'h20, A_CNT = 8'h24;
    localparam logic [31:0] M_LOCK = 32'h8000_0000, M_START = 32'h0002_0000,
                            M_FAIL = 32'h0000_0020, M_TOTAL = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fault_lock_i = 1'b0;
    logic        fault_stat_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] m_state = SEED;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #5 clk = ~clk;

    rng_regfront i_rng_regfront (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .fault_lock_i (fault_lock_i),
        .fault_stat_i (fault_stat_i),
        .irq_o        (irq_o)
    );

    function automatic logic [31:0] model_next(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    // monitor: compares each read against the scoreboard head
    always begin
        @(negedge clk);
        #4;
        if (bus_sel && !bus_wr) begin
            sb_item_t it;
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard underflow got %h exp none", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s got %h exp %h", it.tag,
                             bus_rdata & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e,
                      input logic [31:0] m, input string tag);
        sb_item_t it;
        it.exp = e; it.mask = m; it.tag = tag;
        sbq.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_word(input string tag);
        rd(A_DATA, m_state, 32'hFFFF_FFFF, tag);
        m_state = model_next(m_state);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #4;
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq got %b exp %b", tag, irq_o, e);
        end
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, 0, '1, "R1 ctrl");
        rd(A_CORE, 0, '1, "R1 core hold");
        rd(A_SRC, 0, '1, "R1 src hold");
        rd(A_STAT, 0, '1, "R1 status");
        rd(A_CNT, 0, '1, "R1 count");
        chk_irq(1'b0, "R1");
        // R5 empty read
        rd(A_DATA, 0, '1, "R5 empty data");
        rd(A_CNT, 0, '1, "R5 count after empty read");

        // R10 startup timing
        wr(A_CTRL, 32'h1);
        idle(63);
        rd(A_STAT, 0, M_START, "R10 startup before 64");
        rd(A_STAT, M_START, M_START, "R10 startup at 64");

        // R4 fill and ordered drain, R3 sequence
        rd(A_CNT, 16, '1, "R4 full count");
        for (int i = 0; i < 20; i++) rd_word("R3 R4 word");
        idle(3);

        // R2 enable field value 3 stops production
        wr(A_CTRL, 32'hABCD_0003);
        rd(A_CTRL, 32'hABCD_0003, '1, "R2 readback");
        rd(A_CNT, 16, '1, "R2 count held");
        for (int i = 0; i < 16; i++) rd_word("R2 drain");
        rd(A_DATA, 0, '1, "R2 R5 no refill");
        rd(A_CNT, 0, '1, "R2 count empty");
        wr(A_CTRL, 32'hABCD_0001);
        idle(20);
        rd(A_CNT, 16, '1, "R2 enabled again");

        // R13 undefined offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h0C, 0, '1, "R13 read 0x0C");
        rd(8'h40, 0, '1, "R13 read 0x40");
        rd(A_CTRL, 32'hABCD_0001, '1, "R13 ctrl untouched");
        rd(A_CNT, 16, '1, "R13 count untouched");

        // R9 failure flag halts production
        fault_stat_i = 1'b1;
        @(negedge clk);
        fault_stat_i = 1'b0;
        chk_irq(1'b1, "R12 fail irq");
        rd(A_STAT, M_FAIL, M_FAIL, "R9 fail sticky");
        rd(A_CNT, 16, '1, "R9 count");
        for (int i = 0; i < 16; i++) rd_word("R9 drain");
        rd(A_DATA, 0, '1, "R9 blocked empty");
        rd(A_CNT, 0, '1, "R9 no refill");
        wr(A_STAT, M_FAIL);
        rd(A_STAT, 0, M_FAIL, "R8 fail cleared");
        idle(20);
        rd(A_CNT, 16, '1, "R9 refill after clear");
        rd_word("R9 sequence resumes");
        rd_word("R9 sequence resumes");

        // R9 lockout, R8 selective and full clear
        fault_lock_i = 1'b1;
        @(negedge clk);
        fault_lock_i = 1'b0;
        rd(A_STAT, M_LOCK, M_LOCK, "R9 lockout sticky");
        wr(A_STAT, M_TOTAL);
        rd(A_STAT, M_LOCK, M_LOCK, "R8 other bit kept");
        chk_irq(1'b1, "R12 lock irq");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 0, '1, "R8 all cleared");
        chk_irq(1'b0, "R12 irq low");

        // R6 source hold
        wr(A_SRC, 32'h1);
        rd(A_SRC, 1, '1, "R6 src readback");
        rd(A_CNT, 0, '1, "R6 src flush");
        idle(5);
        rd(A_CNT, 0, '1, "R6 src blocks");
        m_state = SEED;
        wr(A_SRC, 32'h0);
        idle(20);
        rd(A_CNT, 16, '1, "R6 refill");
        for (int i = 0; i < 3; i++) rd_word("R6 R3 restart from seed");
        rd(A_STAT, 0, M_START, "R10 R7 no second startup");

        // R7 core hold restarts startup timer
        wr(A_CORE, 32'h3);
        rd(A_CORE, 1, '1, "R6 core readback");
        rd(A_CNT, 0, '1, "R6 core flush");
        m_state = SEED;
        wr(A_CORE, 32'h0);
        idle(63);
        rd(A_STAT, 0, M_START, "R7 startup before 64");
        rd(A_STAT, M_START, M_START, "R7 startup again");
        wr(A_CORE, 32'h1);
        idle(1);
        rd(A_STAT, 0, M_START, "R7 hold clears startup");
        m_state = SEED;
        wr(A_CORE, 32'h0);

        // R11 word total
        wr(A_STAT, 32'hFFFF_FFFF);
        idle(20);
        for (int i = 0; i < 200; i++) rd_word("R11 R3 long run");
        rd(A_STAT, 0, M_TOTAL, "R11 total not yet");
        for (int i = 0; i < 45; i++) rd_word("R11 R3 long run");
        rd(A_STAT, M_TOTAL, M_TOTAL, "R11 total set");
        chk_irq(1'b1, "R12 total irq");

        idle(2);
        done = 1;
        summary();
        $finish;
    end

endmodule